// File: doc/BRIEF.md
# Banked Active-Priority Register Access Controller

This block holds the four 32-bit active-priority words of one interrupt group and answers system-register read and write requests aimed at them. Each request carries the usual five opcode fields. The block matches one fixed encoding and takes the register index from the two low bits of the last field. It then runs the request through an ordered permission check. The inputs to that check are the requester's privilege level (0 to 3), per-level register-enable bits, a level-2 enable, a trap-all bit for the group, a virtual-routing bit, an IRQ-to-level-3 routing bit and the debug state.

Every matching request gets exactly one response, one clock later. The response is either completed (with read data for a read), undefined-instruction, or a trap naming the target level with syndrome class 0x18. Storage is banked four ways: a secure copy and a non-secure copy used when level 3 exists, a single plain copy used when it does not, and a virtual copy reached through the routing bit. Only a completed write changes storage. A warm reset (`rst_n` low) clears every copy.

Top module: `prio_bank_ctrl`

## Requirements
- R1: A request responds only when op0=3, op1=0, CRn=12, CRm=9 and op2 bit 2 is 0. Any other request, or no request, leaves `rsp_valid` low in the next cycle and changes no storage.
- R2: A matching request accepted at a clock edge gives `rsp_valid`=1 for the cycle after that edge. `rsp_code` is 0 for completed, 1 for undefined and 2 for trap. `rsp_tgt` holds the trap level (1 to 3) and is 0 otherwise. `rsp_ec` is 0x18 on a trap and 0 otherwise.
- R3: Read data bits 63:32 are always zero and write data bits 63:32 are discarded. Bits 31:0 are storage, and all copies read as zero after a warm reset.
- R4: Index 0 always exists. Index 1 needs `PRIO_BITS` of at least 6, and indices 2 and 3 need at least 7. An access to an absent index is undefined.
- R5: Every request from level 0 is undefined. A request from level 3 while `cfg_el3` is 0 is undefined.
- R6: At level 1, the first matching rule wins, in this order. `sre_el1`=0 traps to level 1. `el2_on` together with `trap_grp1` traps to level 2. `el2_on` together with `route_virt` selects the virtual copy. `cfg_el3` together with `el3_irq` traps to level 3. Otherwise the banked copy is used.
- R7: At level 2, the first matching rule wins, in this order. `sre_el2`=0 traps to level 2. `cfg_el3` together with `el3_irq` traps to level 3. Otherwise the banked copy is used. `trap_grp1` and `route_virt` have no effect at this level.
- R8: At level 3, `sre_el3`=0 traps to level 3. Otherwise the access uses the secure copy when `nonsec`=0 and the non-secure copy when `nonsec`=1. The banked copy used at levels 1 and 2 follows the same rule.
- R9: While `cfg_el3`=0, levels 1 and 2 share one plain copy, and `nonsec` and `el3_irq` have no effect.
- R10: The virtual copy is separate storage. Writes through it are not visible in the banked copies, and writes to the banked copies are not visible in it.
- R11: A trap to level 3 caused by `el3_irq` becomes undefined when `dbg_halted` and `dbg_sdd` are both 1.
- R12: A trapped or undefined request changes no storage and returns all-zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset, asynchronous |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Opcode field op0 |
| req_op1 | input | 3 | Opcode field op1 |
| req_crn | input | 4 | Opcode field CRn |
| req_crm | input | 4 | Opcode field CRm |
| req_op2 | input | 3 | Opcode field op2; bits 1:0 give the register index |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Privilege level of the requester |
| cfg_el3 | input | 1 | Level 3 is implemented |
| el2_on | input | 1 | Level 2 is enabled |
| sre_el1 | input | 1 | Register enable for level 1 |
| sre_el2 | input | 1 | Register enable for level 2 |
| sre_el3 | input | 1 | Register enable for level 3 |
| trap_grp1 | input | 1 | Trap all group accesses from level 1 to level 2 |
| route_virt | input | 1 | Redirect level-1 accesses to the virtual copy |
| el3_irq | input | 1 | IRQ routed to level 3 |
| nonsec | input | 1 | Security state: 1 = non-secure |
| dbg_halted | input | 1 | Core is in debug-halted state |
| dbg_sdd | input | 1 | Secure debug disabled |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Outcome: 0 ok, 1 undefined, 2 trap |
| rsp_tgt | output | 2 | Trap target level |
| rsp_ec | output | 6 | Syndrome class |
| rsp_rdata | output | 64 | Read data |

## Verification
A wrong stored word shows up only when that copy is read again. For this reason the bench reads back each copy through a different privilege level and security state than the one that wrote it. A wrong branch in the permission check shows up in the very next response as a wrong outcome or target. A wrong bank choice shows up at the first cross-bank read. A behavioural model follows every request and compares each response in the cycle it appears. Two instances built with different priority widths show errors in the absent-index check.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    localparam int DATA_W    = 64;
    localparam int STORE_W   = 32;
    localparam int NUM_REGS  = 4;
    localparam int NUM_BANKS = 4;
    localparam int EC_W      = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h18;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_UNDEF = 2'd1,
        RES_TRAP  = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        BK_SEC   = 2'd0,
        BK_NS    = 2'd1,
        BK_PLAIN = 2'd2,
        BK_VIRT  = 2'd3
    } bank_e;

    typedef struct packed {
        logic              valid;
        res_e              code;
        logic [1:0]        tgt;
        logic [EC_W-1:0]   ec;
        logic [DATA_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/pbc_decode.sv
module pbc_decode
    import pbc_pkg::*;
#(
    parameter int IMPL = 4
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic [1:0] cur_el,
    input  logic       cfg_el3,
    input  logic       el2_on,
    input  logic       sre_el1,
    input  logic       sre_el2,
    input  logic       sre_el3,
    input  logic       trap_grp1,
    input  logic       route_virt,
    input  logic       el3_irq,
    input  logic       nonsec,
    input  logic       dbg_halted,
    input  logic       dbg_sdd,
    output logic       hit,
    output res_e       code,
    output logic [1:0] tgt,
    output bank_e      bank
);
    logic  idx_ok;
    logic  irq_route;
    bank_e home_bank;

    always_comb begin
        hit       = (op0 == 2'b11) && (op1 == 3'b000) && (crn == 4'b1100)
                    && (crm == 4'b1001) && !op2[2];
        idx_ok    = (int'(op2[1:0]) < IMPL);
        irq_route = cfg_el3 && el3_irq;
        home_bank = !cfg_el3 ? BK_PLAIN : (nonsec ? BK_NS : BK_SEC);
        code      = RES_OK;
        tgt       = 2'd0;
        bank      = home_bank;
        if (cur_el == 2'd0 || !idx_ok) begin
            code = RES_UNDEF;
        end else if (cur_el == 2'd1) begin
            if (!sre_el1) begin
                code = RES_TRAP; tgt = 2'd1;
            end else if (el2_on && trap_grp1) begin
                code = RES_TRAP; tgt = 2'd2;
            end else if (el2_on && route_virt) begin
                bank = BK_VIRT;
            end else if (irq_route) begin
                code = (dbg_halted && dbg_sdd) ? RES_UNDEF : RES_TRAP;
                tgt  = (dbg_halted && dbg_sdd) ? 2'd0 : 2'd3;
            end
        end else if (cur_el == 2'd2) begin
            if (!sre_el2) begin
                code = RES_TRAP; tgt = 2'd2;
            end else if (irq_route) begin
                code = (dbg_halted && dbg_sdd) ? RES_UNDEF : RES_TRAP;
                tgt  = (dbg_halted && dbg_sdd) ? 2'd0 : 2'd3;
            end
        end else begin
            if (!cfg_el3) begin
                code = RES_UNDEF;
            end else if (!sre_el3) begin
                code = RES_TRAP; tgt = 2'd3;
            end
        end
    end
endmodule

// File: rtl/pbc_store.sv
module pbc_store #(
    parameter int NREG  = 4,
    parameter int NBANK = 4,
    parameter int DW    = 32,
    parameter int IMPL  = 4,
    localparam int IW   = $clog2(NREG),
    localparam int BW   = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [BW-1:0] rd_bank,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [NBANK-1:0][DW-1:0] view [NREG];

    for (genvar r = 0; r < NREG; r++) begin : gen_slot
        if (r < IMPL) begin : g_impl
            logic [NBANK-1:0][DW-1:0] slot_d, slot_q;

            always_comb begin
                slot_d = slot_q;
                if (wr_en && (wr_idx == IW'(r))) begin
                    slot_d[wr_bank] = wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end

            assign view[r] = slot_q;
        end else begin : g_absent
            assign view[r] = '0;
        end
    end

    assign rd_data = view[rd_idx][rd_bank];
endmodule

// File: rtl/prio_bank_ctrl.sv
module prio_bank_ctrl
    import pbc_pkg::*;
#(
    parameter int PRIO_BITS = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  cur_el,
    input  logic        cfg_el3,
    input  logic        el2_on,
    input  logic        sre_el1,
    input  logic        sre_el2,
    input  logic        sre_el3,
    input  logic        trap_grp1,
    input  logic        route_virt,
    input  logic        el3_irq,
    input  logic        nonsec,
    input  logic        dbg_halted,
    input  logic        dbg_sdd,
    output logic        rsp_valid,
    output logic [1:0]  rsp_code,
    output logic [1:0]  rsp_tgt,
    output logic [5:0]  rsp_ec,
    output logic [63:0] rsp_rdata
);
    localparam int IMPL = (PRIO_BITS >= 7) ? 4 : ((PRIO_BITS >= 6) ? 2 : 1);

    logic               hit;
    res_e               code;
    logic [1:0]         tgt;
    bank_e              bank;
    logic               wr_en;
    logic [STORE_W-1:0] rd_word;
    rsp_t               rsp_d, rsp_q;

    pbc_decode #(.IMPL(IMPL)) u_decode (
        .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
        .cur_el(cur_el), .cfg_el3(cfg_el3), .el2_on(el2_on),
        .sre_el1(sre_el1), .sre_el2(sre_el2), .sre_el3(sre_el3),
        .trap_grp1(trap_grp1), .route_virt(route_virt), .el3_irq(el3_irq),
        .nonsec(nonsec), .dbg_halted(dbg_halted), .dbg_sdd(dbg_sdd),
        .hit(hit), .code(code), .tgt(tgt), .bank(bank)
    );

    assign wr_en = req_valid && hit && req_write && (code == RES_OK);

    pbc_store #(.NREG(NUM_REGS), .NBANK(NUM_BANKS), .DW(STORE_W), .IMPL(IMPL)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(bank), .wr_idx(req_op2[1:0]),
        .wr_data(req_wdata[STORE_W-1:0]),
        .rd_bank(bank), .rd_idx(req_op2[1:0]), .rd_data(rd_word)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid && hit) begin
            rsp_d.valid = 1'b1;
            rsp_d.code  = code;
            rsp_d.tgt   = tgt;
            rsp_d.ec    = (code == RES_TRAP) ? TRAP_EC : '0;
            if (code == RES_OK && !req_write) begin
                rsp_d.rdata = {{(DATA_W-STORE_W){1'b0}}, rd_word};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_tgt   = rsp_q.tgt;
    assign rsp_ec    = rsp_q.ec;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/pbc_chk.sv
module pbc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic [1:0]  cur_el,
    input logic        cfg_el3,
    input logic        sre_el3,
    input logic        rsp_valid,
    input logic [1:0]  rsp_code,
    input logic [1:0]  rsp_tgt,
    input logic [5:0]  rsp_ec,
    input logic [63:0] rsp_rdata
);
    logic enc_hit;
    assign enc_hit = (req_op0 == 2'b11) && (req_op1 == 3'b000) && (req_crn == 4'b1100)
                     && (req_crm == 4'b1001) && !req_op2[2];

    // R1
    r1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1
    r1_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_hit) |=> !rsp_valid);

    // R2
    r2_trap_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> (rsp_ec == 6'h18 && rsp_tgt != 2'd0));

    // R2
    r2_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'd3));

    // R3
    r3_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[63:32] == 32'h0);

    // R12
    r12_fail_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_rdata == 64'h0));

    // R5
    r5_el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && cur_el == 2'd0) |=> (rsp_valid && rsp_code == 2'd1));

    // R8
    r8_el3_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && cur_el == 2'd3 && cfg_el3 && !sre_el3 && req_op2[1:0] == 2'd0)
        |=> (rsp_code == 2'd2 && rsp_tgt == 2'd3));
endmodule

bind prio_bank_ctrl pbc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .cur_el(cur_el), .cfg_el3(cfg_el3), .sre_el3(sre_el3),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tgt(rsp_tgt),
    .rsp_ec(rsp_ec), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_prio_bank_ctrl.sv
module tb_prio_bank_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_op0 = 2'd3;
    logic [2:0]  req_op1 = 3'd0;
    logic [3:0]  req_crn = 4'd12, req_crm = 4'd9;
    logic [2:0]  req_op2 = 3'd0;
    logic [63:0] req_wdata = 64'h0;
    logic [1:0]  cur_el = 2'd1;
    logic cfg_el3 = 1, el2_on = 1, sre_el1 = 1, sre_el2 = 1, sre_el3 = 1;
    logic trap_grp1 = 0, route_virt = 0, el3_irq = 0, nonsec = 0, dbg_halted = 0, dbg_sdd = 0;

    logic        w_valid, n_valid;
    logic [1:0]  w_code, w_tgt, n_code, n_tgt;
    logic [5:0]  w_ec, n_ec;
    logic [63:0] w_rd, n_rd;

    prio_bank_ctrl #(.PRIO_BITS(7)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el), .cfg_el3(cfg_el3),
        .el2_on(el2_on), .sre_el1(sre_el1), .sre_el2(sre_el2), .sre_el3(sre_el3),
        .trap_grp1(trap_grp1), .route_virt(route_virt), .el3_irq(el3_irq),
        .nonsec(nonsec), .dbg_halted(dbg_halted), .dbg_sdd(dbg_sdd),
        .rsp_valid(w_valid), .rsp_code(w_code), .rsp_tgt(w_tgt), .rsp_ec(w_ec), .rsp_rdata(w_rd)
    );

    prio_bank_ctrl #(.PRIO_BITS(6)) dut_n (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el), .cfg_el3(cfg_el3),
        .el2_on(el2_on), .sre_el1(sre_el1), .sre_el2(sre_el2), .sre_el3(sre_el3),
        .trap_grp1(trap_grp1), .route_virt(route_virt), .el3_irq(el3_irq),
        .nonsec(nonsec), .dbg_halted(dbg_halted), .dbg_sdd(dbg_sdd),
        .rsp_valid(n_valid), .rsp_code(n_code), .rsp_tgt(n_tgt), .rsp_ec(n_ec), .rsp_rdata(n_rd)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] mem_w [4][4];
    logic [31:0] mem_n [4][4];
    logic        xw_v = 0, xn_v = 0;
    logic [1:0]  xw_code = 0, xw_tgt = 0, xn_code = 0, xn_tgt = 0;
    logic [5:0]  xw_ec = 0, xn_ec = 0;
    logic [63:0] xw_rd = 0, xn_rd = 0;

    string cur_tag = "R3";
    int    vectors = 0;
    int    misses  = 0;
    bit    chk_on  = 0;
    bit    done    = 0;

    // outcome 0 ok, 1 undefined, 2 trap; bank 0 secure, 1 non-secure, 2 plain, 3 virtual
    task automatic judge(input int impl, output logic [1:0] code, output logic [1:0] tgt, output int bank);
        int  idx;
        bit  lock;
        idx  = int'(req_op2[1:0]);
        lock = dbg_halted && dbg_sdd;
        code = 2'd0; tgt = 2'd0;
        bank = !cfg_el3 ? 2 : (nonsec ? 1 : 0);
        if (cur_el == 2'd0 || idx >= impl) begin
            code = 2'd1;
        end else if (cur_el == 2'd1) begin
            if (!sre_el1)                      begin code = 2'd2; tgt = 2'd1; end
            else if (el2_on && trap_grp1)      begin code = 2'd2; tgt = 2'd2; end
            else if (el2_on && route_virt)     bank = 3;
            else if (cfg_el3 && el3_irq)       begin code = lock ? 2'd1 : 2'd2; tgt = lock ? 2'd0 : 2'd3; end
        end else if (cur_el == 2'd2) begin
            if (!sre_el2)                      begin code = 2'd2; tgt = 2'd2; end
            else if (cfg_el3 && el3_irq)       begin code = lock ? 2'd1 : 2'd2; tgt = lock ? 2'd0 : 2'd3; end
        end else begin
            if (!cfg_el3)                      code = 2'd1;
            else if (!sre_el3)                 begin code = 2'd2; tgt = 2'd3; end
        end
    endtask

    always @(posedge clk) begin
        logic [1:0] c, t;
        int b, ix;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) begin
                mem_w[i][j] = '0; mem_n[i][j] = '0;
            end
            xw_v = 0; xw_code = 0; xw_tgt = 0; xw_ec = 0; xw_rd = 0;
            xn_v = 0; xn_code = 0; xn_tgt = 0; xn_ec = 0; xn_rd = 0;
        end else begin
            xw_v = 0; xw_code = 0; xw_tgt = 0; xw_ec = 0; xw_rd = 0;
            xn_v = 0; xn_code = 0; xn_tgt = 0; xn_ec = 0; xn_rd = 0;
            ix = int'(req_op2[1:0]);
            if (req_valid && req_op0 == 2'd3 && req_op1 == 3'd0 && req_crn == 4'd12
                && req_crm == 4'd9 && !req_op2[2]) begin
                judge(4, c, t, b);
                xw_v = 1; xw_code = c; xw_tgt = t; xw_ec = (c == 2'd2) ? 6'h18 : 6'h0;
                if (c == 2'd0) begin
                    if (req_write) mem_w[b][ix] = req_wdata[31:0];
                    else           xw_rd = {32'h0, mem_w[b][ix]};
                end
                judge(2, c, t, b);
                xn_v = 1; xn_code = c; xn_tgt = t; xn_ec = (c == 2'd2) ? 6'h18 : 6'h0;
                if (c == 2'd0) begin
                    if (req_write) mem_n[b][ix] = req_wdata[31:0];
                    else           xn_rd = {32'h0, mem_n[b][ix]};
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            vectors++;
            if ({w_valid, w_code, w_tgt, w_ec, w_rd} !== {xw_v, xw_code, xw_tgt, xw_ec, xw_rd}) begin
                misses++;
                $display("FAIL %s wide: got v=%0d code=%0d tgt=%0d ec=%h rd=%h exp v=%0d code=%0d tgt=%0d ec=%h rd=%h",
                         cur_tag, w_valid, w_code, w_tgt, w_ec, w_rd, xw_v, xw_code, xw_tgt, xw_ec, xw_rd);
            end
            vectors++;
            if ({n_valid, n_code, n_tgt, n_ec, n_rd} !== {xn_v, xn_code, xn_tgt, xn_ec, xn_rd}) begin
                misses++;
                $display("FAIL %s narrow: got v=%0d code=%0d tgt=%0d ec=%h rd=%h exp v=%0d code=%0d tgt=%0d ec=%h rd=%h",
                         cur_tag, n_valid, n_code, n_tgt, n_ec, n_rd, xn_v, xn_code, xn_tgt, xn_ec, xn_rd);
            end
        end
    end

    task automatic raw(input bit wr, input logic [1:0] o0, input logic [3:0] cm,
                       input logic [2:0] o2, input logic [63:0] d, input string tag);
        @(negedge clk); #1;
        cur_tag = tag; req_valid = 1; req_write = wr; req_op0 = o0; req_op1 = 3'd0;
        req_crn = 4'd12; req_crm = cm; req_op2 = o2; req_wdata = d;
        @(negedge clk); #1;
        req_valid = 0;
    endtask

    task automatic acc(input bit wr, input logic [2:0] o2, input logic [63:0] d, input string tag);
        raw(wr, 2'd3, 4'd9, o2, d, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        misses++;
        $display("FAIL watchdog: got no finish expected finish");
        finish_run();
    end

    initial begin
        // R3: reset state
        repeat (2) @(posedge clk);
        chk_on = 1;
        @(negedge clk); #1; rst_n = 1;

        // R3 R4: fill and read every index through level 1, secure bank
        for (int i = 0; i < 4; i++)
            acc(1, 3'(i), {32'hFFFF_0000 + 32'(i), 32'hA5A5_0000 + 32'(i)}, "R4");
        for (int i = 0; i < 4; i++) acc(0, 3'(i), 64'h0, "R3");

        // R8: non-secure copy is separate
        nonsec = 1; acc(1, 3'd0, 64'h0000_0000_1234_5678, "R8");
        acc(0, 3'd0, 64'h0, "R8");
        nonsec = 0; acc(0, 3'd0, 64'h0, "R8");
        cur_el = 2'd3; acc(0, 3'd0, 64'h0, "R8");
        nonsec = 1; acc(0, 3'd0, 64'h0, "R8");
        nonsec = 0; sre_el3 = 0; acc(1, 3'd0, 64'hDEAD, "R8");
        sre_el3 = 1; acc(0, 3'd0, 64'h0, "R12");

        // R6: level-1 cascade
        cur_el = 2'd1;
        sre_el1 = 0; trap_grp1 = 1; acc(1, 3'd1, 64'h77, "R6");
        sre_el1 = 1; acc(1, 3'd1, 64'h77, "R6");
        el2_on = 0; acc(0, 3'd1, 64'h0, "R6");
        el2_on = 1; trap_grp1 = 0; route_virt = 1;
        acc(1, 3'd1, 64'h0000_0000_0BAD_F00D, "R10");
        acc(0, 3'd1, 64'h0, "R10");
        route_virt = 0; acc(0, 3'd1, 64'h0, "R10");
        el3_irq = 1; acc(1, 3'd1, 64'h55, "R6");
        dbg_halted = 1; dbg_sdd = 1; acc(0, 3'd1, 64'h0, "R11");
        dbg_sdd = 0; acc(0, 3'd1, 64'h0, "R11");
        dbg_halted = 0; route_virt = 1; acc(0, 3'd1, 64'h0, "R6");
        route_virt = 0; el3_irq = 0;

        // R7: level-2 cascade
        cur_el = 2'd2;
        sre_el2 = 0; acc(1, 3'd2, 64'h99, "R7");
        sre_el2 = 1; el3_irq = 1; acc(0, 3'd2, 64'h0, "R7");
        el3_irq = 0; trap_grp1 = 1; route_virt = 1; acc(0, 3'd2, 64'h0, "R7");
        trap_grp1 = 0; route_virt = 0;

        // R5 R12: level 0 undefined, storage untouched
        cur_el = 2'd0; acc(1, 3'd0, 64'hCAFE, "R5");
        cur_el = 2'd1; acc(0, 3'd0, 64'h0, "R12");

        // R1: encodings that must not respond
        raw(1, 2'd3, 4'd8, 3'd0, 64'h1, "R1");
        raw(1, 2'd3, 4'd9, 3'd4, 64'h2, "R1");
        raw(1, 2'd2, 4'd9, 3'd0, 64'h3, "R1");
        acc(0, 3'd0, 64'h0, "R1");

        // R9: no level 3, single plain copy
        cfg_el3 = 0; acc(1, 3'd2, 64'h0000_0000_00C0_FFEE, "R9");
        nonsec = 1; acc(0, 3'd2, 64'h0, "R9");
        cur_el = 2'd2; el3_irq = 1; acc(0, 3'd2, 64'h0, "R9");
        cur_el = 2'd3; acc(0, 3'd2, 64'h0, "R5");
        cfg_el3 = 1; el3_irq = 0; nonsec = 0; cur_el = 2'd1;

        // R3: warm reset clears storage
        @(negedge clk); #1; rst_n = 0;
        @(negedge clk); #1; rst_n = 1;
        for (int i = 0; i < 4; i++) acc(0, 3'(i), 64'h0, "R3");

        // R2: random mix of levels, controls and encodings
        for (int k = 0; k < 600; k++) begin
            @(negedge clk); #1;
            cur_tag = "R2";
            {cur_el, cfg_el3, el2_on} = 4'($urandom);
            {sre_el1, sre_el2, sre_el3} = ($urandom % 8 == 0) ? 3'($urandom) : 3'b111;
            {trap_grp1, route_virt, el3_irq, nonsec, dbg_halted, dbg_sdd} = 6'($urandom);
            req_valid = ($urandom % 4 != 0);
            req_write = $urandom % 2;
            req_op0   = ($urandom % 10 == 0) ? 2'd1 : 2'd3;
            req_op1   = 3'd0;
            req_crn   = 4'd12;
            req_crm   = ($urandom % 10 == 0) ? 4'd10 : 4'd9;
            req_op2   = 3'($urandom);
            req_wdata = {$urandom, $urandom};
        end
        @(negedge clk); #1; req_valid = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule